// File: doc/BRIEF.md
# Flyback Fault Protection Supervisor

This block is the digital supervisor of a current-mode flyback controller. Its inputs are comparator flags that have already been synchronized: supply above the turn-on level, supply below the turn-off level, supply over-voltage, peak-current limit reached, feedback pin open, and die over-temperature. The over-temperature flag carries its own hysteresis. Two timing inputs complete the set: a strobe that marks the end of each switching cycle and a free-running microsecond tick. The block decides whether the power switch may run. It asks the gate driver to hold the gate low during undervoltage lockout, and it reports its state as a small status code.

The block has five states: lockout, run, overload shutdown, over-voltage shutdown and thermal pause. Lockout ends when the supply climbs past the turn-on level. It begins again only when the supply drops below the turn-off level, so the two comparator levels form the hysteresis. Overload is measured by counting consecutive switching cycles that end in current limit, where an open feedback pin counts as a limited cycle. Over-voltage must persist for a window measured in microsecond ticks before it trips. An over-temperature flag pauses switching without shutting down. Neither shutdown latches: the supply collapses, lockout follows, and the next turn-on restarts the converter. This gives hiccup behaviour that repeats for as long as the fault remains.

Top module: `flyback_guard`

## Requirements
- R1: After reset the status is 1 (lockout), `swEnable` is 0 and `gatePullLow` is 1. This holds while `supplyOn` stays low.
- R2: In lockout, `supplyOn` high with `supplyLow` low moves the block to run on the next clock edge: status 0, `swEnable` 1, `gatePullLow` 0.
- R3: In any state other than lockout, `supplyLow` high returns the block to lockout (status 1) on the next edge. In run, with both supply flags low, the block stays in run.
- R4: In run, `OL_LIMIT` consecutive cycle strobes that each see `peakHit` or `fbOpen` high cause overload shutdown: status 2, `swEnable` 0, `gatePullLow` 0. A strobe that sees neither flag clears the count, so fewer than `OL_LIMIT` consecutive hits never trip.
- R5: While in run or thermal pause, `supplyOvp` held high through `OV_TICKS` microsecond ticks causes over-voltage shutdown (status 3). If the flag drops before the window completes, the count restarts from zero.
- R6: A shutdown (status 2 or 3) persists, ignoring `supplyOn`, until `supplyLow` is seen. The block then enters lockout and restarts on the next turn-on.
- R7: In run, `hotFlag` high gives thermal pause on the next edge: status 4, `swEnable` 0, `gatePullLow` 0. When `hotFlag` clears, the block returns to run. If `supplyLow` is seen during the pause, the block goes to lockout.
- R8: When the over-voltage window and the overload count complete on the same edge, over-voltage wins (status 3). Otherwise the path that completes first sets the shutdown, and the other path cannot change it afterwards.
- R9: Cycle strobes with current limit that arrive outside run (for example during thermal pause) are not counted. On return to run, the overload count starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyOn | input | 1 | Supply above turn-on level |
| supplyLow | input | 1 | Supply below turn-off level |
| supplyOvp | input | 1 | Supply over-voltage comparator |
| peakHit | input | 1 | Peak-current limit reached this cycle |
| fbOpen | input | 1 | Feedback pin open |
| hotFlag | input | 1 | Over-temperature, hysteresis applied |
| cycleStrobe | input | 1 | One-clock pulse at the end of a switching cycle |
| usTick | input | 1 | One-clock pulse every microsecond |
| swEnable | output | 1 | Switching permitted |
| gatePullLow | output | 1 | Hold the gate actively low |
| status | output | 3 | 0 run, 1 lockout, 2 overload, 3 over-voltage, 4 thermal pause |

## Verification
Every internal fault shows at the status port within two clock edges of the strobe or tick that should change it. A counter that resets on a non-hit cycle but fails to clear, or fails to restart after an over-voltage glitch, trips one strobe or tick early or late. The sweeps catch this by checking each count from one to one past the limit. A wrong state transition shows as an incorrect status code, `swEnable` or `gatePullLow` level at the very next edge. A shutdown that leaks out without a supply collapse shows as run status after a turn-on flag is applied.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_UVLO   = 3'd1,
    ST_OLSHUT = 3'd2,
    ST_OVSHUT = 3'd3,
    ST_HOT    = 3'd4
  } supState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clrOl;
    logic clrOv;
  } ctlStrobe_t;

  // datapath -> control trip flags
  typedef struct packed {
    logic olTrip;
    logic ovTrip;
  } dpFlags_t;
endpackage

// File: rtl/fbg_dpath.sv
module fbg_dpath
  import fbg_pkg::*;
#(
  parameter int OL_LIMIT = 2048,
  parameter int OV_TICKS = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t ctl,
  input  logic       peakHit,
  input  logic       fbOpen,
  input  logic       cycleStrobe,
  input  logic       supplyOvp,
  input  logic       usTick,
  output dpFlags_t   flags
);
  localparam int OL_W = $clog2(OL_LIMIT + 1);
  localparam int OV_W = $clog2(OV_TICKS + 1);
  localparam logic [OL_W-1:0] OL_MAX = OL_W'(OL_LIMIT);
  localparam logic [OV_W-1:0] OV_MAX = OV_W'(OV_TICKS);

  logic [OL_W-1:0] olCnt;
  logic [OV_W-1:0] ovCnt;
  logic            limitedCycle;

  // an open feedback pin drives the loop to full current
  assign limitedCycle = peakHit | fbOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      olCnt <= '0;
    end else if (ctl.clrOl) begin
      olCnt <= '0;
    end else if (cycleStrobe) begin
      if (!limitedCycle)       olCnt <= '0;
      else if (olCnt != OL_MAX) olCnt <= olCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovCnt <= '0;
    end else if (ctl.clrOv || !supplyOvp) begin
      ovCnt <= '0;
    end else if (usTick && ovCnt != OV_MAX) begin
      ovCnt <= ovCnt + 1'b1;
    end
  end

  assign flags.olTrip = (olCnt == OL_MAX);
  assign flags.ovTrip = (ovCnt == OV_MAX);

  // R4: a clean cycle clears the overload count
  p_ol_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStrobe && !limitedCycle) |=> (olCnt == '0));

  // R5: deglitch restarts when the flag drops
  p_ov_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOvp |=> (ovCnt == '0));

  // R9: no counting outside run
  p_ol_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrOl |=> (olCnt == '0));

  p_ol_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    olCnt <= OL_MAX);
endmodule

// File: rtl/fbg_ctrl.sv
module fbg_ctrl
  import fbg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOn,
  input  logic       supplyLow,
  input  logic       hotFlag,
  input  dpFlags_t   flags,
  output ctlStrobe_t ctl,
  output logic       swEnable,
  output logic       gatePullLow,
  output logic [2:0] status
);
  supState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_UVLO: if (supplyOn && !supplyLow) stateNext = ST_RUN;
      ST_RUN: begin
        if (supplyLow)          stateNext = ST_UVLO;
        else if (flags.ovTrip)  stateNext = ST_OVSHUT;
        else if (flags.olTrip)  stateNext = ST_OLSHUT;
        else if (hotFlag)       stateNext = ST_HOT;
      end
      ST_HOT: begin
        if (supplyLow)          stateNext = ST_UVLO;
        else if (flags.ovTrip)  stateNext = ST_OVSHUT;
        else if (!hotFlag)      stateNext = ST_RUN;
      end
      ST_OLSHUT, ST_OVSHUT: if (supplyLow) stateNext = ST_UVLO;
      default: stateNext = ST_UVLO;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_UVLO;
    else       state <= stateNext;
  end

  assign ctl.clrOl   = (state != ST_RUN);
  assign ctl.clrOv   = !(state == ST_RUN || state == ST_HOT);
  assign swEnable    = (state == ST_RUN);
  assign gatePullLow = (state == ST_UVLO);
  assign status      = state;

  p_uvlo_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_UVLO && !supplyOn) |=> (state == ST_UVLO));

  p_turn_on_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_UVLO && supplyOn && !supplyLow) |=> (state == ST_RUN));

  p_turn_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_UVLO && supplyLow) |=> (state == ST_UVLO));

  p_shut_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_OLSHUT || state == ST_OVSHUT) && !supplyLow) |=> $stable(state));

  p_pause_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && hotFlag && !supplyLow && !flags.ovTrip && !flags.olTrip)
      |=> (state == ST_HOT));

  p_ov_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !supplyLow && flags.ovTrip) |=> (state == ST_OVSHUT));
endmodule

// File: rtl/flyback_guard.sv
module flyback_guard
  import fbg_pkg::*;
#(
  parameter int OL_LIMIT = 2048,
  parameter int OV_TICKS = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOn,
  input  logic       supplyLow,
  input  logic       supplyOvp,
  input  logic       peakHit,
  input  logic       fbOpen,
  input  logic       hotFlag,
  input  logic       cycleStrobe,
  input  logic       usTick,
  output logic       swEnable,
  output logic       gatePullLow,
  output logic [2:0] status
);
  ctlStrobe_t ctl;
  dpFlags_t   flags;

  fbg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .supplyOn(supplyOn), .supplyLow(supplyLow),
    .hotFlag(hotFlag), .flags(flags), .ctl(ctl), .swEnable(swEnable),
    .gatePullLow(gatePullLow), .status(status)
  );

  fbg_dpath #(.OL_LIMIT(OL_LIMIT), .OV_TICKS(OV_TICKS)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .peakHit(peakHit), .fbOpen(fbOpen),
    .cycleStrobe(cycleStrobe), .supplyOvp(supplyOvp), .usTick(usTick),
    .flags(flags)
  );
endmodule

// File: tb/sim_flyback_guard.sv
`timescale 1ns/1ps
module sim_flyback_guard;
  localparam int OLN = 6;
  localparam int OVN = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOn = 0, supplyLow = 0, supplyOvp = 0, peakHit = 0, fbOpen = 0;
  logic hotFlag = 0, cycleStrobe = 0, usTick = 0;
  logic swEnable, gatePullLow;
  logic [2:0] status;
  int nChk = 0, nBad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flyback_guard #(.OL_LIMIT(OLN), .OV_TICKS(OVN)) u0 (.*);

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [2:0] es, logic ee, logic ep);
    nChk++;
    if (status !== es || swEnable !== ee || gatePullLow !== ep) begin
      nBad++;
      $display("FAIL %s: status/en/pull = %0d/%0b/%0b expected %0d/%0b/%0b",
               req, status, swEnable, gatePullLow, es, ee, ep);
    end
  endtask

  task automatic strobe(logic hit, logic fb);
    peakHit = hit; fbOpen = fb; cycleStrobe = 1; step(1);
    cycleStrobe = 0; peakHit = 0; fbOpen = 0; step(1);
  endtask

  task automatic tick();
    usTick = 1; step(1); usTick = 0; step(1);
  endtask

  // hiccup: supply collapse then turn-on
  task automatic goRun();
    supplyOvp = 0; hotFlag = 0;
    supplyLow = 1; step(1); supplyLow = 0;
    supplyOn = 1; step(1); supplyOn = 0; step(1);
  endtask

  initial begin
    step(2);
    check("R1 reset", 3'd1, 0, 1);
    rstN = 1; step(3);
    check("R1 idle", 3'd1, 0, 1);
    supplyOn = 1; supplyLow = 1; step(1);
    check("R2 both flags", 3'd1, 0, 1);
    supplyLow = 0; step(1);
    check("R2 turn-on", 3'd0, 1, 0);
    supplyOn = 0; step(4);
    check("R3 hysteresis band", 3'd0, 1, 0);
    supplyLow = 1; step(1); supplyLow = 0;
    check("R3 turn-off", 3'd1, 0, 1);

    // R4 sweep over run lengths, peakHit then fbOpen
    for (int src = 0; src < 2; src++) begin
      for (int n = 1; n <= OLN + 1; n++) begin
        goRun();
        for (int k = 0; k < n; k++) begin
          strobe(src == 0, src == 1);
          if (k + 1 < OLN) check("R4 below limit", 3'd0, 1, 0);
        end
        if (n >= OLN) check("R4 overload trip", 3'd2, 0, 0);
        else begin
          strobe(0, 0);
          for (int k = 0; k < OLN - 1; k++) strobe(1, 0);
          check("R4 clean cycle clears count", 3'd0, 1, 0);
        end
      end
    end

    // R5 sweep of glitch widths
    for (int n = 1; n <= OVN + 1; n++) begin
      goRun();
      supplyOvp = 1;
      for (int k = 0; k < n && k < OVN; k++) begin
        if (k + 1 < OVN) begin
          tick();
          check("R5 inside window", 3'd0, 1, 0);
        end else tick();
      end
      if (n >= OVN) check("R5 ovp trip", 3'd3, 0, 0);
      else begin
        supplyOvp = 0; step(1); supplyOvp = 1;
        for (int k = 0; k < OVN - 1; k++) tick();
        check("R5 restart after drop", 3'd0, 1, 0);
        tick();
        check("R5 trip after full window", 3'd3, 0, 0);
      end
    end

    // R6 shutdown held, then hiccup
    supplyOvp = 0; supplyOn = 1; step(3);
    check("R6 shutdown held", 3'd3, 0, 0);
    supplyOn = 0; supplyLow = 1; step(1); supplyLow = 0;
    check("R6 to lockout", 3'd1, 0, 1);
    supplyOn = 1; step(1); supplyOn = 0;
    check("R6 restart", 3'd0, 1, 0);

    // R7 / R9 thermal pause
    hotFlag = 1; step(1);
    check("R7 pause", 3'd4, 0, 0);
    for (int k = 0; k < OLN + 2; k++) strobe(1, 0);
    check("R9 no count in pause", 3'd4, 0, 0);
    hotFlag = 0; step(1);
    check("R7 resume", 3'd0, 1, 0);
    for (int k = 0; k < OLN - 1; k++) strobe(1, 0);
    check("R9 count restarted", 3'd0, 1, 0);
    hotFlag = 1; step(1);
    supplyLow = 1; step(1); supplyLow = 0; hotFlag = 0;
    check("R7 low supply in pause", 3'd1, 0, 1);

    // R8 simultaneous completion: over-voltage wins
    goRun();
    supplyOvp = 1;
    for (int k = 0; k < OVN - 1; k++) tick();
    for (int k = 0; k < OLN - 1; k++) strobe(1, 0);
    check("R8 armed", 3'd0, 1, 0);
    usTick = 1; cycleStrobe = 1; peakHit = 1; step(1);
    usTick = 0; cycleStrobe = 0; peakHit = 0; step(1);
    check("R8 same edge", 3'd3, 0, 0);
    // overload first, then full over-voltage window
    goRun();
    for (int k = 0; k < OLN; k++) strobe(1, 0);
    supplyOvp = 1;
    for (int k = 0; k < OVN + 1; k++) tick();
    check("R8 first wins", 3'd2, 0, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule